// File: doc/BRIEF.md
# Configurable Storage Bit with Set and Reset Options

This block holds one bit of state. A parameter builds it either as an edge-triggered flip-flop or as a level-sensitive latch. It takes a data input with a clock enable. It has two force inputs. `sr` drives the bit to a value chosen by a parameter. `rev` drives the bit to the opposite value, but only when a parameter turns it on. A third parameter decides whether these force inputs are ignored, act in step with the clock, or act immediately without a clock.

Across its parameters the cell gives seven set/reset options: none; synchronous set; synchronous reset; synchronous set with reset; asynchronous preset; asynchronous clear; asynchronous preset with clear. Each option can be built in flop or latch form. A global init pulse `gsr` loads the parameterised initial value and overrides every other input.

Top module: `cfgbit_cell`

## Requirements
- R1: While `gsr` is high, `q` equals `INIT_VAL` at once, whatever the other inputs do. After `gsr` falls, `q` keeps that value until another input changes it.
- R2: With `IS_LATCH`=0 and `ce` high, `q` takes `d` at the rising edge of `clk`. With `IS_LATCH`=1 and `ce` high, `q` follows `d` while `clk` is high and holds it while `clk` is low.
- R3: With `ce` low and no force input active, `q` holds its value and changes of `d` have no effect.
- R4: With `SR_KIND`=SRK_SYNC, an active force input sets `q` at the rising clock edge (flop) or while `clk` is high (latch), even when `ce` is low. It has no effect while `clk` is low before that edge.
- R5: With `SR_KIND`=SRK_ASYNC, an active force input sets `q` at once, with no clock edge. If a clock edge passes while the force input is held, `q` keeps the forced value after the input is released.
- R6: With `SR_KIND`=SRK_ASYNC and both the drive-to-1 and drive-to-0 requests active, `q` is 0.
- R7: With `SR_KIND`=SRK_SYNC and both the drive-to-1 and drive-to-0 requests active, `q` becomes 0.
- R8: `sr` drives `q` to 1 when `SR_TO_ONE`=1 and to 0 when `SR_TO_ONE`=0. `rev` drives `q` to the opposite value only when `REV_EN`=1; when `REV_EN`=0, `rev` is ignored.
- R9: With `SR_KIND`=SRK_NONE, `sr` and `rev` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock: the capture edge in flop form, the transparency level in latch form |
| ce | input | 1 | Clock enable for data capture |
| d | input | 1 | Data input |
| sr | input | 1 | Force input, drives to the `SR_TO_ONE` value |
| rev | input | 1 | Opposite force input, active only when `REV_EN`=1 |
| gsr | input | 1 | Global init pulse, loads `INIT_VAL` |
| q | output | 1 | Stored bit |

## Verification
The bench builds fourteen cells at once, one for each of the seven options in each of the two storage forms. It alternates the initial value between cells, so every set or reset moves at least one cell away from its initial value. Data patterns with the enable high and then low show whether capture is correctly gated. A change of `d` while `clk` is high separates the latch form from the flop form. The force inputs are driven alone and together, and `q` is sampled before the clock edge and again after it. The sample before the edge separates the asynchronous options from the synchronous ones, and driving both inputs together checks the precedence rules. An init pulse raised with every other input active checks that it overrides them all.

// File: rtl/cfgbit_pkg.sv
package cfgbit_pkg;

  // Which kind of action the force inputs have on the stored bit.
  typedef enum logic [1:0] {
    SRK_NONE  = 2'd0,
    SRK_SYNC  = 2'd1,
    SRK_ASYNC = 2'd2
  } srk_e;

  // Resolve two force requests into {active, value}. Drive-to-0 wins.
  function automatic logic [1:0] pick_force(input logic to_one, input logic to_zero);
    return {to_one | to_zero, to_one & ~to_zero};
  endfunction

endpackage

// File: rtl/cfgbit_sr_decode.sv
module cfgbit_sr_decode
  import cfgbit_pkg::*;
#(
  parameter srk_e SR_KIND   = SRK_SYNC,
  parameter bit   SR_TO_ONE = 1'b1,
  parameter bit   REV_EN    = 1'b0
) (
  input  logic sr,
  input  logic rev,
  output logic sync_set,
  output logic sync_clr,
  output logic async_set,
  output logic async_clr
);

  localparam bit SYNC_ON  = (SR_KIND == SRK_SYNC);
  localparam bit ASYNC_ON = (SR_KIND == SRK_ASYNC);

  logic rev_act;
  logic to_one;
  logic to_zero;

  assign rev_act = REV_EN & rev;
  assign to_one  = SR_TO_ONE ? sr : rev_act;
  assign to_zero = SR_TO_ONE ? rev_act : sr;

  assign sync_set  = SYNC_ON  & to_one;
  assign sync_clr  = SYNC_ON  & to_zero;
  assign async_set = ASYNC_ON & to_one;
  assign async_clr = ASYNC_ON & to_zero;

endmodule

// File: rtl/cfgbit_flop_core.sv
module cfgbit_flop_core (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic sync_set,
  input  logic sync_clr,
  input  logic frc_act,
  input  logic frc_val,
  output logic q
);

  logic q_r;

  always_ff @(posedge clk or posedge frc_act) begin
    if (frc_act)       q_r <= frc_val;
    else if (sync_clr) q_r <= 1'b0;
    else if (sync_set) q_r <= 1'b1;
    else if (ce)       q_r <= d;
  end

  // A held force is visible at once, without waiting for an edge.
  assign q = frc_act ? frc_val : q_r;

endmodule

// File: rtl/cfgbit_latch_core.sv
module cfgbit_latch_core (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic sync_set,
  input  logic sync_clr,
  input  logic frc_act,
  input  logic frc_val,
  output logic q
);

  logic q_r;

  always_latch begin
    if (frc_act) begin
      q_r = frc_val;
    end else if (clk) begin
      if (sync_clr)      q_r = 1'b0;
      else if (sync_set) q_r = 1'b1;
      else if (ce)       q_r = d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/cfgbit_cell.sv
module cfgbit_cell
  import cfgbit_pkg::*;
#(
  parameter bit   IS_LATCH  = 1'b0,
  parameter bit   INIT_VAL  = 1'b0,
  parameter srk_e SR_KIND   = SRK_SYNC,
  parameter bit   SR_TO_ONE = 1'b1,
  parameter bit   REV_EN    = 1'b0
) (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic sr,
  input  logic rev,
  input  logic gsr,
  output logic q
);

  // Named internal events, brought out for the checker.
  logic       sync_set;
  logic       sync_clr;
  logic       async_set;
  logic       async_clr;
  logic [1:0] frc_pick;
  logic       frc_act;
  logic       frc_val;

  cfgbit_sr_decode #(
    .SR_KIND  (SR_KIND),
    .SR_TO_ONE(SR_TO_ONE),
    .REV_EN   (REV_EN)
  ) u_dec (
    .sr       (sr),
    .rev      (rev),
    .sync_set (sync_set),
    .sync_clr (sync_clr),
    .async_set(async_set),
    .async_clr(async_clr)
  );

  // The init pulse outranks the asynchronous requests.
  assign frc_pick = pick_force(async_set, async_clr);
  assign frc_act  = gsr | frc_pick[1];
  assign frc_val  = gsr ? INIT_VAL : frc_pick[0];

  generate
    if (IS_LATCH) begin : g_latch
      cfgbit_latch_core u_core (
        .clk(clk), .ce(ce), .d(d),
        .sync_set(sync_set), .sync_clr(sync_clr),
        .frc_act(frc_act), .frc_val(frc_val), .q(q)
      );
    end else begin : g_flop
      cfgbit_flop_core u_core (
        .clk(clk), .ce(ce), .d(d),
        .sync_set(sync_set), .sync_clr(sync_clr),
        .frc_act(frc_act), .frc_val(frc_val), .q(q)
      );
    end
  endgenerate

endmodule

// File: rtl/cfgbit_chk.sv
module cfgbit_chk
  import cfgbit_pkg::*;
#(
  parameter bit   IS_LATCH = 1'b0,
  parameter bit   INIT_VAL = 1'b0,
  parameter srk_e SR_KIND  = SRK_SYNC
) (
  input logic clk,
  input logic ce,
  input logic d,
  input logic gsr,
  input logic q,
  input logic sync_set,
  input logic sync_clr,
  input logic async_set,
  input logic async_clr
);

  localparam bit FLOP     = !IS_LATCH;
  localparam bit NO_ASYNC = (SR_KIND != SRK_ASYNC);

  assert_init_load_R1: assert property (@(negedge clk)
    gsr |-> q == INIT_VAL);

  assert_async_preset_R5: assert property (@(negedge clk) disable iff (gsr)
    (async_set && !async_clr) |-> q == 1'b1);

  assert_async_clear_wins_R6: assert property (@(negedge clk) disable iff (gsr)
    async_clr |-> q == 1'b0);

  assert_sync_reset_wins_R7: assert property (@(posedge clk) disable iff (gsr)
    (FLOP && sync_clr) |=> q == 1'b0);

  assert_sync_set_R4: assert property (@(posedge clk) disable iff (gsr)
    (FLOP && sync_set && !sync_clr) |=> q == 1'b1);

  assert_flop_capture_R2: assert property (@(posedge clk) disable iff (gsr)
    (FLOP && NO_ASYNC && ce && !sync_set && !sync_clr) |=> q == $past(d));

  assert_ce_hold_R3: assert property (@(posedge clk) disable iff (gsr)
    (FLOP && NO_ASYNC && !ce && !sync_set && !sync_clr) |=> $stable(q));

endmodule

bind cfgbit_cell cfgbit_chk #(
  .IS_LATCH(IS_LATCH),
  .INIT_VAL(INIT_VAL),
  .SR_KIND (SR_KIND)
) u_chk (
  .clk      (clk),
  .ce       (ce),
  .d        (d),
  .gsr      (gsr),
  .q        (q),
  .sync_set (sync_set),
  .sync_clr (sync_clr),
  .async_set(async_set),
  .async_clr(async_clr)
);

// File: tb/cfgbit_cell_tb_top.sv
`timescale 1ns/100ps
module cfgbit_cell_tb_top;
  import cfgbit_pkg::*;

  localparam int NCELL = 14;

  logic clk = 1'b0;
  logic ce = 1'b0, d = 1'b0, sr = 1'b0, rev = 1'b0, gsr = 1'b1;
  logic [NCELL-1:0] qv;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Cell i: form = latch when i >= 7; option = i % 7
  // 0 none, 1 sync set, 2 sync reset, 3 sync set+reset,
  // 4 async preset, 5 async clear, 6 async preset+clear. Initial value = i % 2.
  for (genvar i = 0; i < NCELL; i++) begin : g_dut
    localparam int OPT = i % 7;
    cfgbit_cell #(
      .IS_LATCH (1'(i >= 7)),
      .INIT_VAL (1'(i % 2)),
      .SR_KIND  (OPT == 0 ? SRK_NONE : (OPT < 4 ? SRK_SYNC : SRK_ASYNC)),
      .SR_TO_ONE(1'(!(OPT == 2 || OPT == 5))),
      .REV_EN   (1'(OPT == 3 || OPT == 6))
    ) dut_i (
      .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .gsr(gsr), .q(qv[i])
    );
  end

  function automatic bit init_of(int i);
    return 1'(i % 2);
  endfunction

  // Value expected once the force inputs s/r have been seen by a clock edge (R4-R9).
  function automatic bit settled(int i, bit s, bit r);
    int opt = i % 7;
    bit iv = init_of(i);
    case (opt)
      1, 4:    return s ? 1'b1 : iv;
      2, 5:    return s ? 1'b0 : iv;
      3, 6:    return r ? 1'b0 : (s ? 1'b1 : iv);
      default: return iv;
    endcase
  endfunction

  task automatic check(bit got, bit exp, string req, int idx);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cell %0d: got %b expected %b", req, idx, got, exp);
    end
  endtask

  task automatic to_drive();
    @(negedge clk); #0.5;
  endtask

  task automatic to_sample();
    @(posedge clk); #1;
  endtask

  task automatic do_init();
    to_drive();
    gsr = 1'b1; sr = 1'b0; rev = 1'b0; ce = 1'b0; d = 1'b0;
    to_sample();
    to_drive();
    gsr = 1'b0;
  endtask

  // R1: init value, and override of every other input.
  task automatic t_init();
    do_init();
    to_sample();
    for (int i = 0; i < NCELL; i++) check(qv[i], init_of(i), "R1 reset", i);
    to_drive();
    gsr = 1'b1; sr = 1'b1; rev = 1'b1; ce = 1'b1; d = 1'b1;
    #0.5;
    for (int i = 0; i < NCELL; i++) check(qv[i], init_of(i), "R1 override immediate", i);
    to_sample();
    for (int i = 0; i < NCELL; i++) check(qv[i], init_of(i), "R1 override at edge", i);
    do_init();
  endtask

  // R2 and R3: capture under enable, hold without it.
  task automatic t_capture();
    bit pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    do_init();
    foreach (pat[k]) begin
      to_drive();
      ce = 1'b1; d = pat[k];
      to_sample();
      for (int i = 0; i < NCELL; i++) check(qv[i], pat[k], "R2 capture", i);
    end
    to_drive();
    ce = 1'b0; d = 1'b0;
    to_sample();
    to_sample();
    for (int i = 0; i < NCELL; i++) check(qv[i], 1'b1, "R3 hold with ce low", i);
  endtask

  // R2: latch follows d while clk is high, flop waits for the next edge.
  task automatic t_form();
    do_init();
    to_drive();
    ce = 1'b1; d = 1'b0;
    to_sample();
    d = 1'b1;
    #0.5;
    for (int i = 0; i < NCELL; i++) check(qv[i], i >= 7, "R2 mid-high change", i);
    to_drive();
    for (int i = 0; i < NCELL; i++) check(qv[i], i >= 7, "R2 low phase hold", i);
    ce = 1'b0;
  endtask

  // R4-R9: one force pattern from the initial state.
  task automatic t_force(bit s, bit r, string tag);
    do_init();
    to_drive();
    ce = 1'b0; d = 1'b1; sr = s; rev = r;
    #0.5;
    for (int i = 0; i < NCELL; i++)
      check(qv[i], (i % 7 >= 4) ? settled(i, s, r) : init_of(i),
            {tag, " before edge (R4 R5)"}, i);
    to_sample();
    for (int i = 0; i < NCELL; i++)
      check(qv[i], settled(i, s, r), {tag, " after edge (R4 R6 R7 R8 R9)"}, i);
    to_drive();
    sr = 1'b0; rev = 1'b0;
    to_sample();
    for (int i = 0; i < NCELL; i++)
      check(qv[i], settled(i, s, r), {tag, " after release (R5)"}, i);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_init();
    t_capture();
    t_form();
    t_force(1'b1, 1'b0, "sr only");
    t_force(1'b0, 1'b1, "rev only");
    t_force(1'b1, 1'b1, "sr and rev");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule